// File: doc/BRIEF.md
# Multi-Port Refuse-and-Retry Request Front-End

This block sits between several requester ports and one back-end that can work on only one request at a time. Each cycle it accepts at most one request and forwards it with its address to the back-end. It remembers which port that request came from, and it routes the back-end's single response back to that port only. A request that cannot be taken is refused, and the refusal is remembered in a per-port pending flag. The port then receives a one-cycle retry pulse once taking a new request is possible again. The requester resends after the pulse.

A requester may also decline a response that is offered to it. The declined response then waits in a one-entry slot belonging to that port. The slot re-offers the response whenever the requester raises its response-retry input, and the requester may decline it again. While a port's slot is occupied, that port takes no new requests and receives no retry pulse. As a result, a back-end response can never land on an occupied slot. When requests collide, the lowest-numbered eligible port wins.

Top module: `retry_frontend`

## Requirements
- R1: While a request is outstanding (accepted, with its back-end response not yet returned), every valid request is refused (req_accept low) and that port becomes retry-pending.
- R2: A port whose response slot is occupied, or that is already retry-pending, refuses a valid request and stays retry-pending. A back-end response is never routed to a port whose slot is occupied.
- R3: With no request outstanding, the lowest-indexed port whose request is valid and that is neither pending nor holding a response is accepted in the same cycle. be_req_valid is high in that cycle with that port's address on be_req_addr. The other valid requesters are refused and become pending.
- R4: In the cycle be_rsp_valid is high, rsp_valid is raised on the port that issued the outstanding request and on no other port. That port's rsp_data lane carries be_rsp_data in the same cycle.
- R5: If the owning port holds rsp_accept low in the delivery cycle, the response is kept in its slot. In every later cycle with rsp_retry high, rsp_valid is raised with the kept data. The slot empties only in a cycle where rsp_retry and rsp_accept are both high.
- R6: A retry opportunity for a port is a cycle with be_rsp_valid high, or a cycle in which that port's slot empties. If, at the end of such a cycle, the port is pending (including a refusal made in that same cycle) and its slot is empty, then retry pulses high for exactly the next cycle and the pending flag clears.
- R7: No retry pulse is produced for a port while its response slot is occupied. Such a port stays pending until its slot empties.
- R8: After reset every port is idle with an empty slot and no pending flag. The outputs req_accept, rsp_valid, retry and be_req_valid are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NPORT | Request present, one bit per port |
| req_addr | input | NPORT*AW | Request address, lane i at bits i*AW |
| req_accept | output | NPORT | Request taken this cycle (low = refused) |
| rsp_valid | output | NPORT | Response offered to the port |
| rsp_data | output | NPORT*DW | Response data, lane i at bits i*DW |
| rsp_accept | input | NPORT | Requester takes the offered response |
| rsp_retry | input | NPORT | Requester asks for its held response again |
| retry | output | NPORT | One-cycle pulse: resend the refused request |
| be_req_valid | output | 1 | Request issued to the back-end |
| be_req_addr | output | AW | Address of the issued request |
| be_rsp_valid | input | 1 | Back-end response for the outstanding request |
| be_rsp_data | input | DW | Back-end response data |

## Verification
Two events can fall in the same cycle, and the bench forces both. First, a back-end completion can coincide with a fresh refusal. Second, a response can be declined into the slot in the same cycle that other ports hold pending flags. The directed part lines up such cycles on purpose: a refusal in the completion cycle, and a stash into the slot while two ports wait. A random phase then mixes requests, declines and re-offers at high density against latencies of zero to three cycles. A bench model built from the requirements predicts every output in every cycle. It judges whether the pulse lands on exactly the right port one cycle later, and never on a port whose slot is full.

// File: rtl/rfe_pkg.sv
package rfe_pkg;
  // width of a port index, at least one bit
  function automatic int unsigned idx_bits(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // retry decision for one port at the end of a cycle
  function automatic logic retry_due(input logic pend_next, input logic slot_next,
                                     input logic opportunity);
    return pend_next && !slot_next && opportunity;
  endfunction
endpackage

// File: rtl/rfe_arbiter.sv
module rfe_arbiter
  import rfe_pkg::*;
#(
  parameter int unsigned NPORT = 2,
  localparam int unsigned IW = idx_bits(NPORT)
) (
  input  logic [NPORT-1:0] eligible,
  output logic [NPORT-1:0] grant,
  output logic [IW-1:0]    grant_idx,
  output logic             any_grant
);
  always_comb begin
    grant     = '0;
    grant_idx = '0;
    for (int i = NPORT - 1; i >= 0; i--) begin
      if (eligible[i]) begin
        grant     = '0;
        grant[i]  = 1'b1;
        grant_idx = IW'(i);
      end
    end
  end
  assign any_grant = |eligible;

  always_comb begin
    AST_GRANT_ELIGIBLE: assert ((grant & ~eligible) == '0); // R3
  end
endmodule

// File: rtl/rfe_owner.sv
module rfe_owner #(
  parameter int unsigned IW = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic [IW-1:0] accept_idx,
  input  logic          done,
  output logic          busy,
  output logic [IW-1:0] owner
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      owner <= '0;
    end else begin
      if (done) busy <= 1'b0;
      if (accept) begin
        busy  <= 1'b1;
        owner <= accept_idx;
      end
    end
  end

  AST_ACCEPT_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> !busy); // R1
  AST_ACCEPT_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy && owner == $past(accept_idx)); // R4
endmodule

// File: rtl/rfe_port.sv
module rfe_port
  import rfe_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          granted,
  input  logic          be_idle,
  input  logic          deliver,
  input  logic          be_done,
  input  logic [DW-1:0] deliver_data,
  input  logic          rsp_accept,
  input  logic          rsp_retry,
  output logic          eligible,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic          retry
);
  logic          pend_q, slot_q;
  logic [DW-1:0] slot_data_q;
  // named events for the assertions
  logic refuse, offer_held, drain, stash, pend_next, slot_next, opportunity, fire;

  assign eligible    = req_valid && !slot_q && !pend_q && be_idle;
  assign refuse      = req_valid && !granted;
  assign pend_next   = pend_q || refuse;
  assign offer_held  = slot_q && rsp_retry;
  assign rsp_valid   = deliver || offer_held;
  assign rsp_data    = deliver ? deliver_data : slot_data_q;
  assign drain       = offer_held && rsp_accept;
  assign stash       = deliver && !rsp_accept;
  assign slot_next   = stash || (slot_q && !drain);
  assign opportunity = be_done || drain;
  assign fire        = retry_due(pend_next, slot_next, opportunity);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q      <= 1'b0;
      slot_q      <= 1'b0;
      slot_data_q <= '0;
      retry       <= 1'b0;
    end else begin
      pend_q <= pend_next && !fire;
      slot_q <= slot_next;
      retry  <= fire;
      if (stash) slot_data_q <= deliver_data;
    end
  end

  AST_NO_SLOT_CLOBBER: assert property (@(posedge clk) disable iff (!rst_n)
    deliver |-> !slot_q); // R2
  AST_REFUSE_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
    refuse |=> pend_q || retry); // R1
  AST_HELD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    slot_q && !drain |=> slot_q && $stable(slot_data_q)); // R5
  AST_RETRY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    retry |-> !pend_q && !slot_q); // R6
  AST_NO_RETRY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    slot_q && !drain |=> !retry); // R7
endmodule

// File: rtl/retry_frontend.sv
module retry_frontend
  import rfe_pkg::*;
#(
  parameter int unsigned NPORT = 2,
  parameter int unsigned AW    = 16,
  parameter int unsigned DW    = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NPORT-1:0]   req_valid,
  input  logic [NPORT*AW-1:0] req_addr,
  output logic [NPORT-1:0]   req_accept,
  output logic [NPORT-1:0]   rsp_valid,
  output logic [NPORT*DW-1:0] rsp_data,
  input  logic [NPORT-1:0]   rsp_accept,
  input  logic [NPORT-1:0]   rsp_retry,
  output logic [NPORT-1:0]   retry,
  output logic               be_req_valid,
  output logic [AW-1:0]      be_req_addr,
  input  logic               be_rsp_valid,
  input  logic [DW-1:0]      be_rsp_data
);
  localparam int unsigned IW = idx_bits(NPORT);

  logic [NPORT-1:0] eligible, grant, deliver;
  logic [IW-1:0]    grant_idx, owner;
  logic             any_grant, busy;

  rfe_arbiter #(.NPORT(NPORT)) u_arb (
    .eligible (eligible),
    .grant    (grant),
    .grant_idx(grant_idx),
    .any_grant(any_grant)
  );

  rfe_owner #(.IW(IW)) u_owner (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (any_grant),
    .accept_idx(grant_idx),
    .done      (be_rsp_valid),
    .busy      (busy),
    .owner     (owner)
  );

  for (genvar i = 0; i < NPORT; i++) begin : g_port
    localparam logic [IW-1:0] PID = IW'(i);
    assign deliver[i] = be_rsp_valid && (owner == PID);

    rfe_port #(.DW(DW)) u_port (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_valid   (req_valid[i]),
      .granted     (grant[i]),
      .be_idle     (!busy),
      .deliver     (deliver[i]),
      .be_done     (be_rsp_valid),
      .deliver_data(be_rsp_data),
      .rsp_accept  (rsp_accept[i]),
      .rsp_retry   (rsp_retry[i]),
      .eligible    (eligible[i]),
      .rsp_valid   (rsp_valid[i]),
      .rsp_data    (rsp_data[i*DW +: DW]),
      .retry       (retry[i])
    );
  end

  assign req_accept   = grant;
  assign be_req_valid = any_grant;
  assign be_req_addr  = req_addr[grant_idx*AW +: AW];

  AST_ONE_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_accept)); // R3
  AST_SINGLE_DELIVERY: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(deliver) <= 1); // R4
  AST_NO_ISSUE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    be_req_valid |=> !be_req_valid || $past(be_rsp_valid)); // R1
endmodule

// File: tb/retry_frontend_test.sv
`timescale 1ns/1ps
module retry_frontend_test;
  localparam int N  = 3;
  localparam int AW = 8;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0]    req_valid = '0, rsp_accept = '0, rsp_retry = '0;
  logic [N*AW-1:0] req_addr = '0;
  logic [N-1:0]    req_accept, rsp_valid, retry;
  logic [N*DW-1:0] rsp_data;
  logic            be_req_valid;
  logic [AW-1:0]   be_req_addr;
  logic            be_rsp_valid = 1'b0;
  logic [DW-1:0]   be_rsp_data = '0;

  always #2.5 clk = ~clk;

  retry_frontend #(.NPORT(N), .AW(AW), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_accept(req_accept), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .rsp_accept(rsp_accept), .rsp_retry(rsp_retry), .retry(retry),
    .be_req_valid(be_req_valid), .be_req_addr(be_req_addr),
    .be_rsp_valid(be_rsp_valid), .be_rsp_data(be_rsp_data)
  );

  int checks = 0, fails = 0;
  bit finished = 0;

  // bench model state
  logic [N-1:0] m_pend = '0, m_slot = '0, m_retry = '0;
  logic [DW-1:0] m_sd [N];
  logic m_busy = 1'b0;
  int m_owner = 0, m_lat = 0, fixed_lat = -1;
  logic [AW-1:0] m_baddr = '0;

  task automatic chk(input string tag, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, got, exp, $time);
    end
  endtask

  function automatic logic [N-1:0] pick_lowest(input logic [N-1:0] v);
    for (int i = 0; i < N; i++) if (v[i]) return N'(1) << i;
    return '0;
  endfunction

  function automatic logic [DW-1:0] backend_data(input logic [AW-1:0] a);
    return DW'(a) ^ 8'h5A;
  endfunction

  task automatic run_cycle(input logic [N-1:0] rv, input logic [N*AW-1:0] ra,
                           input logic [N-1:0] acc, input logic [N-1:0] rtr);
    logic bv;
    logic [DW-1:0] bd;
    logic [N-1:0] elig, g;
    string tag;
    @(negedge clk);
    for (int i = 0; i < N; i++)
      chk(m_slot[i] ? "R7" : "R6", $sformatf("retry[%0d]", i), retry[i], m_retry[i]);
    bv = m_busy && (m_lat == 0);
    bd = backend_data(m_baddr);
    req_valid = rv; req_addr = ra; rsp_accept = acc; rsp_retry = rtr;
    be_rsp_valid = bv; be_rsp_data = bd;
    #1;
    elig = m_busy ? '0 : (rv & ~m_pend & ~m_slot);
    g = pick_lowest(elig);
    if (m_busy && rv != 0) tag = "R1";
    else if ((rv & (m_pend | m_slot)) != 0) tag = "R2";
    else tag = "R3";
    chk(tag, "req_accept", req_accept, g);
    chk("R3", "be_req_valid", be_req_valid, g != 0);
    for (int i = 0; i < N; i++)
      if (g[i]) chk("R3", "be_req_addr", be_req_addr, ra[i*AW +: AW]);
    for (int i = 0; i < N; i++) begin
      logic dl, off;
      dl  = bv && (m_owner == i);
      off = m_slot[i] && rtr[i];
      chk(off ? "R5" : "R4", $sformatf("rsp_valid[%0d]", i), rsp_valid[i], dl | off);
      if (dl | off)
        chk(off ? "R5" : "R4", $sformatf("rsp_data[%0d]", i), rsp_data[i*DW +: DW],
            dl ? bd : m_sd[i]);
    end
    // advance the model
    for (int i = 0; i < N; i++) begin
      logic dl, off, pn, drn, st, sn, f;
      dl  = bv && (m_owner == i);
      off = m_slot[i] && rtr[i];
      pn  = m_pend[i] | (rv[i] & ~g[i]);
      drn = off & acc[i];
      st  = dl & ~acc[i];
      sn  = st | (m_slot[i] & ~drn);
      if (st) m_sd[i] = bd;
      f = pn & ~sn & (bv | drn);
      m_retry[i] = f;
      m_pend[i]  = pn & ~f;
      m_slot[i]  = sn;
    end
    if (bv) m_busy = 1'b0;
    else if (m_busy) m_lat--;
    for (int i = 0; i < N; i++) if (g[i]) begin
      m_busy = 1'b1; m_owner = i; m_baddr = ra[i*AW +: AW];
      m_lat = (fixed_lat >= 0) ? fixed_lat : int'($urandom % 4);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_5678));
    for (int i = 0; i < N; i++) m_sd[i] = '0;
    repeat (3) @(negedge clk);
    // R8: reset state
    chk("R8", "req_accept", req_accept, 0);
    chk("R8", "rsp_valid", rsp_valid, 0);
    chk("R8", "retry", retry, 0);
    chk("R8", "be_req_valid", be_req_valid, 0);
    rst_n = 1'b1;

    // directed corners, back-end answers two cycles after accept
    fixed_lat = 1;
    run_cycle(3'b010, {8'h00, 8'h33, 8'h00}, 3'b111, 3'b000); // p1 accepted R3
    run_cycle(3'b001, {8'h00, 8'h00, 8'h11}, 3'b111, 3'b000); // p0 refused busy R1
    run_cycle(3'b001, {8'h00, 8'h00, 8'h11}, 3'b111, 3'b000); // refusal in completion cycle R4 R6
    run_cycle(3'b111, {8'hC2, 8'hB1, 8'hA0}, 3'b111, 3'b000); // p0 retry, collision, lowest wins
    run_cycle(3'b000, '0, 3'b111, 3'b000);
    run_cycle(3'b000, '0, 3'b000, 3'b000);                     // response declined -> slot R5
    run_cycle(3'b001, {8'h00, 8'h00, 8'hA0}, 3'b000, 3'b001); // slot full refuses R2, reoffer declined
    run_cycle(3'b000, '0, 3'b000, 3'b000);                     // no retry while held R7
    run_cycle(3'b000, '0, 3'b001, 3'b001);                     // drain -> retry next R6
    run_cycle(3'b000, '0, 3'b000, 3'b000);
    run_cycle(3'b000, '0, 3'b000, 3'b000);

    // constrained random phase
    fixed_lat = -1;
    for (int c = 0; c < 4000; c++) begin
      logic [N-1:0] rv, acc, rtr;
      logic [N*AW-1:0] ra;
      for (int i = 0; i < N; i++) begin
        rv[i]  = ($urandom % 2) == 0;
        acc[i] = ($urandom % 5) < 3;
        rtr[i] = ($urandom % 5) < 2;
      end
      ra = N*AW'($urandom);
      run_cycle(rv, ra, acc, rtr);
    end
    run_cycle('0, '0, '1, '0);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule